// File: doc/BRIEF.md
# Timestamped Sample Packet Deframer

The deframer takes in packets as a stream of 36-bit words under a valid/ready handshake. Each word carries 32 data bits and a flag nibble. Bit 32 marks the first word of a packet and bit 33 marks the last word. Each packet has five leading words: a header, a stream identifier, a whole-seconds time word, and a fractional time split into a high word followed by a low word. After these come the payload samples and, optionally, one trailer word.

The header's length field is counted down as payload arrives. Every payload sample becomes one 100-bit entry for a downstream sample queue. An entry holds a 64-bit timestamp, four flag bits and the 32-bit sample. The trailer is consumed and not forwarded.

Packets are discarded in three cases: the header is malformed, the stream identifier does not match a stored value while filtering is enabled, or the end marker disagrees with the length count. A small settings bus holds the compare value and the filter enable.

Top module: `pkt_deframer`

## Requirements
- R1: An input word transfers only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low whenever a held output entry is not being taken (`out_valid` high and `out_ready` low). An output entry appears only after an input transfer.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R3: A word with bit 32 set is accepted as a header only if all of these hold: bits 31:28 equal 1; bit 33 is clear; the length in bits 15:0 is at least 6, or at least 7 when bit 26 (trailer present) is set. Otherwise the whole packet produces no output.
- R4: `out_data[99:36]` carries {fractional-high word, fractional-low word} from words 4 and 5 of the packet. `out_data[31:0]` carries the sample. The seconds word and header bits 27 and 23:16 do not affect the output.
- R5: The flag field is `out_data[35:32]`. Bit 32 is start-of-packet and bit 34 is time-valid; both are set only on the first sample. Bit 33 is end-of-packet and is set on the sample where the count (length − 5 − trailer) is used up. Bit 35 is always 0.
- R6: When a trailer is present, the word after the last sample is consumed and forwarded nowhere.
- R7: The parser drops the rest of a packet in three cases: a word before the last counted sample carries the end flag; the last sample lacks the end flag when there is no trailer; or the last sample carries the end flag when a trailer is expected. The offending sample is not forwarded. Samples already forwarded remain.
- R8: A word with bit 32 set always starts a new header parse, even in the middle of a packet. Words without bit 32 that arrive while waiting for a header are discarded.
- R9: Settings writes use offset 0 from the base address (default 16) for the 32-bit stream-identifier compare value and offset 1, bit 0 for the filter enable. Both reset to 0. Writes to other addresses have no effect.
- R10: With the filter enabled, a packet whose stream identifier differs from the compare value produces no output. With the filter disabled, any identifier passes.
- R11: Active-low reset, and a high `clear` on a clock edge, both empty the output entry and return the parser to waiting for a header. Any partial packet is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous flush of parser and output entry |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings write address |
| set_data | input | 32 | Settings write data |
| in_data | input | 36 | Input word: flags in 35:32, data in 31:0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| out_data | output | 100 | Entry: timestamp 99:36, flags 35:32, sample 31:0 |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Downstream queue takes the entry |

## Verification
The assertions assume that downstream only uses `out_ready` as a take signal and never requires an entry to be withdrawn. They also assume that `clear` is a synchronous pulse seen on a clock edge. The bench changes every input only on the falling clock edge. It randomises `out_ready` and gaps in `in_valid`, so the stall-hold and ready-gating properties are exercised many times. The stimulus is free to send malformed packets, because the assertions check only handshake and flag-field behaviour, which must hold for any word stream.

// File: rtl/pkt_deframer_pkg.sv
// Shared constants and parser state type for the packet deframer.
// Assumes a 4-bit flag field placed just above the sample in each entry.
package pkt_deframer_pkg;
    localparam int FLAG_W     = 4;
    localparam int FL_SOP     = 0;
    localparam int FL_EOP     = 1;
    localparam int FL_TV      = 2;
    localparam int FL_RSV     = 3;
    localparam int HDR_WORDS  = 5;
    localparam logic [3:0] PKT_TYPE_DATA = 4'd1;

    typedef enum logic [2:0] {
        ST_WAIT, ST_SID, ST_SECS, ST_THI, ST_TLO, ST_PAY, ST_TRL
    } parse_st_t;
endpackage

// File: rtl/pkt_cfg_regs.sv
// Settings-bus register file: stream-id compare value and filter enable.
// Assumes single-cycle write strobes; unknown addresses are ignored.
module pkt_cfg_regs #(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int BASE_ADDR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_stb,
    input  logic [AW-1:0] set_addr,
    input  logic [DW-1:0] set_data,
    output logic [DW-1:0] sid_cmp,
    output logic          sid_en
);
    localparam logic [AW-1:0] ADDR_SID = AW'(BASE_ADDR);
    localparam logic [AW-1:0] ADDR_CTL = AW'(BASE_ADDR + 1);

    // Capture writes addressed to this block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_cmp <= '0;
            sid_en  <= 1'b0;
        end else if (set_stb) begin
            if (set_addr == ADDR_SID) sid_cmp <= set_data;
            if (set_addr == ADDR_CTL) sid_en  <= set_data[0];
        end
    end
endmodule

// File: rtl/pkt_hdr_parser.sv
// Walks each packet word by word, checks the header and length count,
// and flags each payload word that must become an output entry.
// Assumes word_take is only high when the output stage can load.
module pkt_hdr_parser
    import pkt_deframer_pkg::*;
#(
    parameter int DW   = 32,
    parameter int LENW = 16,
    parameter int TSW  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              word_take,
    input  logic [DW+3:0]     word,
    input  logic [DW-1:0]     sid_cmp,
    input  logic              sid_en,
    output logic              emit,
    output logic [TSW-1:0]    emit_ts,
    output logic [FLAG_W-1:0] emit_flags,
    output logic [DW-1:0]     emit_sample
);
    localparam int HALF = TSW / 2;

    parse_st_t        st;
    logic [LENW-1:0]  rem;
    logic             has_tr;
    logic             first;
    logic [HALF-1:0]  ts_hi, ts_lo;

    logic [DW-1:0]    wdata;
    logic             sof, eof, last, pay_ok, hdr_ok, hdr_tr;
    logic [LENW-1:0]  hdr_len;

    // Decode the current word and payload consistency.
    always_comb begin
        wdata   = word[DW-1:0];
        sof     = word[DW];
        eof     = word[DW+1];
        hdr_tr  = wdata[26];
        hdr_len = wdata[LENW-1:0];
        hdr_ok  = (wdata[31:28] == PKT_TYPE_DATA) && !eof &&
                  (hdr_len >= LENW'(HDR_WORDS + 1) + LENW'(hdr_tr));
        last    = (rem == LENW'(1));
        pay_ok  = last ? (has_tr ? !eof : eof) : !eof;
    end

    // Advance the parse state on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st     <= ST_WAIT;
            rem    <= '0;
            has_tr <= 1'b0;
            first  <= 1'b0;
            ts_hi  <= '0;
            ts_lo  <= '0;
        end else if (word_take) begin
            if (sof) begin
                st     <= hdr_ok ? ST_SID : ST_WAIT;
                rem    <= hdr_len - LENW'(HDR_WORDS) - LENW'(hdr_tr);
                has_tr <= hdr_tr;
                first  <= 1'b1;
            end else begin
                unique case (st)
                    ST_WAIT: st <= ST_WAIT;
                    ST_SID:  st <= (eof || (sid_en && wdata != sid_cmp)) ? ST_WAIT : ST_SECS;
                    ST_SECS: st <= eof ? ST_WAIT : ST_THI;
                    ST_THI: begin
                        ts_hi <= wdata[HALF-1:0];
                        st    <= eof ? ST_WAIT : ST_TLO;
                    end
                    ST_TLO: begin
                        ts_lo <= wdata[HALF-1:0];
                        st    <= eof ? ST_WAIT : ST_PAY;
                    end
                    ST_PAY: begin
                        if (!pay_ok) begin
                            st <= ST_WAIT;
                        end else begin
                            first <= 1'b0;
                            rem   <= rem - LENW'(1);
                            if (last) st <= has_tr ? ST_TRL : ST_WAIT;
                        end
                    end
                    ST_TRL:  st <= ST_WAIT;
                    default: st <= ST_WAIT;
                endcase
            end
        end
    end

    // Form the entry for a forwarded payload word.
    always_comb begin
        emit        = word_take && !sof && (st == ST_PAY) && pay_ok;
        emit_ts     = {ts_hi, ts_lo};
        emit_sample = wdata;
        emit_flags  = '0;
        emit_flags[FL_SOP] = first;
        emit_flags[FL_TV]  = first;
        emit_flags[FL_EOP] = last;
    end
endmodule

// File: rtl/pkt_out_stage.sv
// One-entry output register toward the sample queue.
// Assumes load is only raised while free is high.
module pkt_out_stage #(
    parameter int EW = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [EW-1:0] load_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [EW-1:0] out_data,
    output logic          free
);
    // Hold an entry until the queue takes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // The slot can load when empty or being emptied this cycle.
    always_comb free = !out_valid || out_ready;
endmodule

// File: rtl/pkt_deframer.sv
// Top of the deframer: settings registers, parser and output register.
// Assumes a single sample channel per entry.
module pkt_deframer
    import pkt_deframer_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int LENW      = 16,
    parameter int TSW       = 64,
    parameter int BASE_ADDR = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    set_stb,
    input  logic [AW-1:0]           set_addr,
    input  logic [DW-1:0]           set_data,
    input  logic [DW+3:0]           in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic [TSW+FLAG_W+DW-1:0] out_data,
    output logic                    out_valid,
    input  logic                    out_ready
);
    localparam int EW = TSW + FLAG_W + DW;

    logic [DW-1:0]     sid_cmp;
    logic              sid_en;
    logic              free, take, emit;
    logic [TSW-1:0]    emit_ts;
    logic [FLAG_W-1:0] emit_flags;
    logic [DW-1:0]     emit_sample;

    // Input is accepted only when the output slot can take a result.
    always_comb begin
        in_ready = free;
        take     = in_valid && free;
    end

    pkt_cfg_regs #(.AW(AW), .DW(DW), .BASE_ADDR(BASE_ADDR)) u_cfg (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_addr(set_addr),
        .set_data(set_data), .sid_cmp(sid_cmp), .sid_en(sid_en)
    );

    pkt_hdr_parser #(.DW(DW), .LENW(LENW), .TSW(TSW)) u_parse (
        .clk(clk), .rst_n(rst_n), .clear(clear), .word_take(take),
        .word(in_data), .sid_cmp(sid_cmp), .sid_en(sid_en), .emit(emit),
        .emit_ts(emit_ts), .emit_flags(emit_flags), .emit_sample(emit_sample)
    );

    pkt_out_stage #(.EW(EW)) u_out (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load(emit),
        .load_data({emit_ts, emit_flags, emit_sample}), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .free(free)
    );
endmodule

// File: rtl/pkt_deframer_chk.sv
// Handshake and flag-field properties of the deframer, bound to the top.
module pkt_deframer_chk #(
    parameter int DW = 32,
    parameter int EW = 100
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [EW-1:0] out_data
);
    // R1
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1
    entry_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_data)));

    // R5
    rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_data[DW+3]);

    // R11
    clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);
endmodule

bind pkt_deframer pkt_deframer_chk #(.DW(DW), .EW(EW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/test_pkt_deframer.sv
module test_pkt_deframer;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0;
    logic         set_stb = 1'b0;
    logic [7:0]   set_addr = '0;
    logic [31:0]  set_data = '0;
    logic [35:0]  in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [99:0]  out_data;
    logic         out_valid;
    logic         out_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit stall = 0;
    bit done = 0;
    logic [99:0] expq[$];
    logic [35:0] pktq[$];

    pkt_deframer i_pkt_deframer (
        .clk(clk), .rst_n(rst_n), .clear(clear), .set_stb(set_stb),
        .set_addr(set_addr), .set_data(set_data), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [99:0] act, input logic [99:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [99:0] entry(input logic [31:0] thi, input logic [31:0] tlo,
                                          input int i, input int n, input logic [31:0] s);
        logic [3:0] f;
        f = {1'b0, (i == 0), (i == n - 1), (i == 0)};
        return {thi, tlo, f, s};
    endfunction

    // One clock: drive at the falling edge, observe both handshakes, then wait.
    task automatic cycle(input logic v, input logic [35:0] w, output bit took);
        logic [99:0] e;
        @(negedge clk);
        in_valid  = v;
        in_data   = w;
        out_ready = stall ? 1'b0 : (($urandom % 4) != 0);
        #1;
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk(0, "R7 unexpected entry", out_data, '0);
            end else begin
                e = expq.pop_front();
                chk(out_data == e, "R4 R5 entry content", out_data, e);
            end
        end
        took = v && in_ready;
        @(posedge clk);
    endtask

    task automatic send_word(input logic [35:0] w);
        bit t;
        do begin
            if (($urandom % 4) == 0) cycle(1'b0, '0, t);
            cycle(1'b1, w, t);
        end while (!t);
    endtask

    task automatic send_all();
        while (pktq.size() != 0) send_word(pktq.pop_front());
    endtask

    task automatic drain(input string req);
        bit t;
        repeat (30) cycle(1'b0, '0, t);
        chk(expq.size() == 0, req, 100'(expq.size()), '0);
        expq.delete();
    endtask

    task automatic write_set(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        set_stb = 1'b1; set_addr = a; set_data = d;
        @(negedge clk);
        set_stb = 1'b0;
    endtask

    // mode: 0 good, 1 early end flag, 2 missing end flag, 3 end flag on last
    // sample with trailer, 4 wrong packet type, 5 length too short.
    task automatic build_pkt(input logic [31:0] sid, input int n, input bit tr_in,
                             input int mode, input bit pass);
        logic [31:0] thi, tlo, s;
        bit tr;
        int len, k;
        logic [3:0] typ;
        tr  = (mode == 3) ? 1'b1 : (mode == 2) ? 1'b0 : tr_in;
        len = (mode == 5) ? 5 + int'(tr) : 5 + n + int'(tr);
        typ = (mode == 4) ? 4'h2 : 4'h1;
        thi = $urandom; tlo = $urandom;
        k   = (mode == 1) ? n - 2 : n;
        pktq.push_back({4'b0001, typ, 1'b0, tr, 2'b11, 8'hF0, 16'(len)});
        pktq.push_back({4'b0000, sid});
        pktq.push_back({4'b0000, 32'($urandom)});
        pktq.push_back({4'b0000, thi});
        pktq.push_back({4'b0000, tlo});
        for (int i = 0; i < n; i++) begin
            bit e;
            s = $urandom;
            e = (i == k) || (i == n - 1 && !tr && mode != 2) || (i == n - 1 && mode == 3);
            pktq.push_back({2'b00, e, 1'b0, s});
            if (pass && mode != 4 && mode != 5 && i < k &&
                !((mode == 2 || mode == 3) && i == n - 1))
                expq.push_back(entry(thi, tlo, i, n, s));
        end
        if (tr) pktq.push_back({4'b0010, 32'h600D_7A11});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit t;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(out_valid == 1'b0, "R11 reset out_valid", 100'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", 100'(in_ready), 1);

        // R9 filter off at reset: any stream id passes; R4 R5 basic
        build_pkt(32'hDEAD_0001, 1, 0, 0, 1); send_all(); drain("R9 reset filter off");
        // R6 trailer consumed
        build_pkt(32'hDEAD_0002, 4, 1, 0, 1); send_all(); drain("R6 trailer not forwarded");
        // R3 bad type and short length
        build_pkt(32'h1, 3, 0, 4, 0); send_all(); drain("R3 bad type ignored");
        build_pkt(32'h1, 3, 1, 5, 0); send_all(); drain("R3 short length ignored");
        // R7 drop cases
        build_pkt(32'h2, 5, 0, 1, 1); send_all(); drain("R7 early end flag");
        build_pkt(32'h3, 4, 0, 2, 1); send_all(); drain("R7 missing end flag");
        build_pkt(32'h4, 3, 1, 3, 1); send_all(); drain("R7 end flag before trailer");
        build_pkt(32'h5, 2, 0, 0, 1); send_all(); drain("R8 recovery after drop");
        // R8 restart in mid packet
        build_pkt(32'h6, 4, 0, 0, 0);
        repeat (3) send_word(pktq.pop_front());
        pktq.delete();
        build_pkt(32'h7, 3, 1, 0, 1); send_all(); drain("R8 sop restarts parse");

        // R9 R10 filter
        write_set(8'(BASE), 32'hF00D_1234);
        write_set(8'(BASE + 1), 32'h1);
        build_pkt(32'hF00D_1234, 3, 0, 0, 1); send_all(); drain("R10 match passes");
        build_pkt(32'h1234_5678, 3, 0, 0, 0); send_all(); drain("R10 mismatch dropped");
        write_set(8'(BASE + 9), 32'h0);
        write_set(8'(BASE + 2), 32'h0);
        build_pkt(32'hF00D_1234, 2, 1, 0, 1); send_all(); drain("R9 other address ignored");
        build_pkt(32'h1234_5678, 2, 0, 0, 0); send_all(); drain("R9 filter still on");
        write_set(8'(BASE + 1), 32'h0);
        build_pkt(32'h1234_5678, 2, 0, 0, 1); send_all(); drain("R10 filter disabled passes");

        // R11 clear mid packet
        build_pkt(32'h8, 4, 0, 0, 0);
        repeat (6) send_word(pktq.pop_front());
        @(negedge clk); in_valid = 1'b0; out_ready = 1'b0; clear = 1'b1;
        @(negedge clk); clear = 1'b0; #1;
        chk(out_valid == 1'b0, "R11 clear empties entry", 100'(out_valid), 0);
        send_all(); drain("R11 clear discards packet");

        // R1 R2 back-pressure
        stall = 1;
        build_pkt(32'h9, 3, 0, 0, 1);
        repeat (6) send_word(pktq.pop_front());
        cycle(1'b1, pktq[0], t);
        chk(!t, "R1 in_ready low while stalled", 100'(t), 0);
        chk(out_valid == 1'b1, "R2 entry held", 100'(out_valid), 1);
        stall = 0;
        send_all(); drain("R2 stalled packet delivered");

        // Random packets
        for (int p = 0; p < 40; p++) begin
            int n, m;
            n = 1 + int'($urandom % 8);
            m = int'($urandom % 4);
            if (m == 1 && n < 2) m = 0;
            build_pkt($urandom, n, 1'($urandom), m, 1);
            send_all();
        end
        drain("R7 random stream all matched");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule